// File: doc/BRIEF.md
# Nibble-Bus Flash Read Target

This block answers read cycles on a 4-bit multiplexed firmware bus, clocked by the bus clock. It watches the frame strobe and the inbound nibbles for a start code and compares the following nibble with its ID strap pins. It then collects a 28-bit address and a size code. When the cycle is addressed to it and the size code is legal, it takes over the bus. It drives the sync nibbles and returns one or more bytes, each as two nibbles with the low nibble first. After the last byte it drives a turnaround nibble and then releases the bus.

Bytes come from a synchronous read port with one cycle of latency. The block presents an address and a read strobe one cycle before it captures the data. The fixed sync cycles absorb this latency for the first byte. For a burst, each later byte is requested while the low nibble of the current byte is on the bus. Address bit 22 selects the target. When it is set, the read goes to the memory array and only the low 20 address bits are kept. When it is clear, the read goes to register space with the full address. A burst starts at the address aligned to its length and steps upward.

Top module: `nbr_target`

## Requirements
- R1: A cycle begins at a rising clock edge where `frame_n` is low and `bus_in` is 1101b. The next nibble is compared with `id_strap`, and on a match the block responds.
- R2: When the ID nibble differs from `id_strap`, the block ignores the rest of the cycle. `bus_oe` and `rd_en` stay low.
- R3: The seven nibbles after the ID form a 28-bit address, most significant nibble first.
- R4: Size code 0, 1, 2, 4 or 7 selects 2^code bytes. The first read uses the address with its low `code` bits cleared, and each following byte uses the next higher address.
- R5: After the size nibble the host owns one turnaround cycle. The block then drives 1111b for one clock, 0101b for exactly two clocks and 0000b for one clock, with `bus_oe` high.
- R6: With address bit 22 set, `rd_regsp` is 0 and `rd_addr` keeps bits 19:0 with all higher bits zero. With bit 22 clear, `rd_regsp` is 1 and all 28 bits are kept.
- R7: Each byte takes two clocks, bits 3:0 first and then bits 7:4. After the last byte the block drives 1111b for one clock, and `bus_oe` is low on the clock after that.
- R8: A size code other than 0, 1, 2, 4 or 7 abandons the cycle, and the bus is never driven.
- R9: `frame_n` low in any non-idle state aborts the cycle at that edge. If `bus_in` is 1101b at that edge, a new cycle starts instead.
- R10: During and after reset, `bus_oe` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Frame strobe, active low |
| bus_in | input | 4 | Nibble received from the bus |
| bus_out | output | 4 | Nibble driven onto the bus |
| bus_oe | output | 1 | Output enable for `bus_out` |
| id_strap | input | 4 | Static device ID straps |
| rd_en | output | 1 | Byte read strobe |
| rd_addr | output | 28 | Byte read address |
| rd_regsp | output | 1 | 1 selects register space, 0 the memory array |
| rd_data | input | 8 | Read data, valid one cycle after `rd_en` |

## Verification
The bench runs reads at every legal burst length from unaligned start addresses, so stepping from the wrong base shows up as wrong data. Register-space and array addresses with junk in the ignored high bits tell the two kinds of masking apart. Mismatched IDs and reserved size codes are compared against matching legal cycles to show that only a valid header ever drives the bus. Aborts during the address and during the data phase check the return to idle and the restart. A mix of random cycles with a fixed seed covers the combinations in between.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
   localparam int           NIB_W      = 4;
   localparam int           BYTE_W     = 8;
   localparam int           MAX_LOG    = 7;
   localparam int           BURST_W    = MAX_LOG + 1;
   localparam logic [3:0]   NIB_START  = 4'b1101;
   localparam logic [3:0]   NIB_TAR    = 4'b1111;
   localparam logic [3:0]   NIB_WSYNC  = 4'b0101;
   localparam logic [3:0]   NIB_RSYNC  = 4'b0000;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ID, ST_ADDR, ST_SIZE, ST_HTAR, ST_TTAR,
      ST_WAIT, ST_READY, ST_DLO, ST_DHI, ST_ETAR
   } nbr_state_e;

   function automatic logic size_ok(input logic [3:0] c);
      return (c == 4'd0) || (c == 4'd1) || (c == 4'd2) || (c == 4'd4) || (c == 4'd7);
   endfunction

   function automatic logic [BURST_W-1:0] burst_last(input logic [3:0] c);
      return BURST_W'((9'd1 << c[2:0]) - 9'd1);
   endfunction
endpackage

// File: rtl/nbr_seq.sv
module nbr_seq
   import nbr_pkg::*;
#(
   parameter int ADDR_NIBS  = 7,
   parameter int WAIT_SYNCS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic [3:0] bus_in,
   input  logic [3:0] id_strap,
   output nbr_state_e state,
   output logic       addr_shift,
   output logic       size_take,
   output logic       rd_issue,
   output logic       byte_load
);
   localparam int CNT_MAX = (ADDR_NIBS > WAIT_SYNCS) ? ADDR_NIBS : WAIT_SYNCS;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (ADDR_NIBS < 1) begin : g_bad_nibs
      $error("nbr_seq: ADDR_NIBS must be at least 1");
   end
   if (WAIT_SYNCS < 1) begin : g_bad_wait
      $error("nbr_seq: WAIT_SYNCS must be at least 1");
   end

   nbr_state_e         state_q, state_d;
   logic [CNT_W-1:0]   cnt_q, cnt_d;
   logic [BURST_W-1:0] left_q, left_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      left_d  = left_q;
      if (state_q != ST_IDLE && !frame_n) begin
         state_d = (bus_in == NIB_START) ? ST_ID : ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE:  if (!frame_n && bus_in == NIB_START) state_d = ST_ID;
            ST_ID: begin
               if (bus_in == id_strap) begin
                  state_d = ST_ADDR;
                  cnt_d   = '0;
               end else begin
                  state_d = ST_IDLE;
               end
            end
            ST_ADDR: begin
               if (cnt_q == CNT_W'(ADDR_NIBS - 1)) state_d = ST_SIZE;
               else                                cnt_d   = cnt_q + 1'b1;
            end
            ST_SIZE: begin
               if (size_ok(bus_in)) begin
                  state_d = ST_HTAR;
                  left_d  = burst_last(bus_in);
               end else begin
                  state_d = ST_IDLE;
               end
            end
            ST_HTAR:  state_d = ST_TTAR;
            ST_TTAR: begin
               state_d = ST_WAIT;
               cnt_d   = '0;
            end
            ST_WAIT: begin
               if (cnt_q == CNT_W'(WAIT_SYNCS - 1)) state_d = ST_READY;
               else                                 cnt_d   = cnt_q + 1'b1;
            end
            ST_READY: state_d = ST_DLO;
            ST_DLO:   state_d = ST_DHI;
            ST_DHI: begin
               if (left_q == '0) begin
                  state_d = ST_ETAR;
               end else begin
                  left_d  = left_q - 1'b1;
                  state_d = ST_DLO;
               end
            end
            ST_ETAR:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         left_q  <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         left_q  <= left_d;
      end
   end

   assign state      = state_q;
   assign addr_shift = (state_q == ST_ADDR) && frame_n;
   assign size_take  = (state_q == ST_SIZE) && frame_n && size_ok(bus_in);
   assign rd_issue   = ((state_q == ST_WAIT) && (cnt_q == CNT_W'(WAIT_SYNCS - 1))) ||
                       ((state_q == ST_DLO) && (left_q != '0));
   assign byte_load  = (state_q == ST_READY) || ((state_q == ST_DHI) && (left_q != '0));

   AST_START_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !frame_n && bus_in == NIB_START) |=> state_q == ST_ID); // R1
   AST_ID_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ID && frame_n && bus_in != id_strap) |=> state_q == ST_IDLE); // R2
   AST_TWO_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READY) |-> ($past(state_q) == ST_WAIT && $past(state_q, 2) == ST_WAIT)); // R5
   AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SIZE && frame_n && !size_ok(bus_in)) |=> state_q == ST_IDLE); // R8
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && !frame_n && bus_in != NIB_START) |=> state_q == ST_IDLE); // R9
endmodule

// File: rtl/nbr_addr.sv
module nbr_addr
   import nbr_pkg::*;
#(
   parameter int ADDR_NIBS = 7,
   parameter int SPACE_BIT = 22,
   parameter int ARRAY_W   = 20,
   localparam int ADDR_W   = NIB_W * ADDR_NIBS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        bus_in,
   input  logic              addr_shift,
   input  logic              size_take,
   input  logic              rd_issue,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_regsp
);
   if (SPACE_BIT >= ADDR_W) begin : g_bad_space
      $error("nbr_addr: SPACE_BIT must lie inside the address");
   end
   if (ARRAY_W > SPACE_BIT || ARRAY_W <= MAX_LOG) begin : g_bad_array
      $error("nbr_addr: ARRAY_W must exceed the burst span and not reach SPACE_BIT");
   end

   logic [ADDR_W-1:0] addr_q, align_mask, keep_mask;
   logic              regsp_q;

   assign align_mask = ~((ADDR_W'(1) << bus_in[2:0]) - ADDR_W'(1));

   for (genvar b = 0; b < ADDR_W; b++) begin : g_keep
      if (b < ARRAY_W) begin : g_low
         assign keep_mask[b] = 1'b1;
      end else begin : g_high
         assign keep_mask[b] = ~addr_q[SPACE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         regsp_q <= 1'b0;
      end else if (addr_shift) begin
         addr_q  <= {addr_q[ADDR_W-NIB_W-1:0], bus_in};
      end else if (size_take) begin
         addr_q  <= addr_q & align_mask & keep_mask;
         regsp_q <= ~addr_q[SPACE_BIT];
      end else if (rd_issue) begin
         addr_q  <= addr_q + 1'b1;
      end
   end

   assign rd_addr  = addr_q;
   assign rd_regsp = regsp_q;

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_issue |=> rd_addr == $past(rd_addr) + 1'b1); // R4
   AST_ARRAY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_issue && !rd_regsp) |-> (rd_addr >> ARRAY_W) == '0); // R6
endmodule

// File: rtl/nbr_drive.sv
module nbr_drive
   import nbr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  nbr_state_e        state,
   input  logic              byte_load,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [3:0]        bus_out,
   output logic              bus_oe
);
   logic [BYTE_W-1:0] byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         byte_q <= '0;
      else if (byte_load) byte_q <= rd_data;
   end

   always_comb begin
      bus_oe  = 1'b1;
      bus_out = NIB_TAR;
      case (state)
         ST_TTAR:  bus_out = NIB_TAR;
         ST_WAIT:  bus_out = NIB_WSYNC;
         ST_READY: bus_out = NIB_RSYNC;
         ST_DLO:   bus_out = byte_q[3:0];
         ST_DHI:   bus_out = byte_q[7:4];
         ST_ETAR:  bus_out = NIB_TAR;
         default:  bus_oe  = 1'b0;
      endcase
   end

   AST_TAKEOVER_TAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> bus_out == NIB_TAR); // R5
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ETAR) |=> !bus_oe); // R7
endmodule

// File: rtl/nbr_target.sv
module nbr_target
   import nbr_pkg::*;
#(
   parameter int ADDR_NIBS  = 7,
   parameter int WAIT_SYNCS = 2,
   parameter int SPACE_BIT  = 22,
   parameter int ARRAY_W    = 20,
   localparam int ADDR_W    = NIB_W * ADDR_NIBS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [3:0]        bus_in,
   output logic [3:0]        bus_out,
   output logic              bus_oe,
   input  logic [3:0]        id_strap,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_regsp,
   input  logic [7:0]        rd_data
);
   nbr_state_e state;
   logic       addr_shift, size_take, byte_load;

   nbr_seq #(.ADDR_NIBS(ADDR_NIBS), .WAIT_SYNCS(WAIT_SYNCS)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_n    (frame_n),
      .bus_in     (bus_in),
      .id_strap   (id_strap),
      .state      (state),
      .addr_shift (addr_shift),
      .size_take  (size_take),
      .rd_issue   (rd_en),
      .byte_load  (byte_load)
   );

   nbr_addr #(.ADDR_NIBS(ADDR_NIBS), .SPACE_BIT(SPACE_BIT), .ARRAY_W(ARRAY_W)) i_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_in     (bus_in),
      .addr_shift (addr_shift),
      .size_take  (size_take),
      .rd_issue   (rd_en),
      .rd_addr    (rd_addr),
      .rd_regsp   (rd_regsp)
   );

   nbr_drive i_drive (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .byte_load  (byte_load),
      .rd_data    (rd_data),
      .bus_out    (bus_out),
      .bus_oe     (bus_oe)
   );

   AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst_n) |=> (!bus_oe && !rd_en)); // R10
endmodule

// File: tb/test_nbr_target.sv
`timescale 1ns/1ps
module test_nbr_target;
   localparam logic [3:0] STRAP = 4'h3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  bus_in = 4'hF;
   logic [3:0]  bus_out;
   logic        bus_oe;
   logic [3:0]  id_strap = STRAP;
   logic        rd_en;
   logic [27:0] rd_addr;
   logic        rd_regsp;
   logic [7:0]  rd_data = 8'h00;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   nbr_target i_nbr_target (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .id_strap(id_strap),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_regsp(rd_regsp), .rd_data(rd_data)
   );

   function automatic logic [7:0] mem_byte(input logic regsp, input logic [27:0] a);
      return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ {4'h0, a[27:24]} ^ (regsp ? 8'hC3 : 8'h00);
   endfunction

   function automatic logic [27:0] exp_base(input logic [27:0] a, input logic [3:0] c);
      logic [27:0] e;
      e = a[22] ? {8'h00, a[19:0]} : a;
      return e & ~((28'd1 << c[2:0]) - 28'd1);
   endfunction

   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= mem_byte(rd_regsp, rd_addr);
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(input logic f, input logic [3:0] n);
      @(negedge clk);
      frame_n = f;
      bus_in  = n;
   endtask

   task automatic send_header(input logic [3:0] id, input logic [27:0] a, input logic [3:0] c);
      drive(1'b0, 4'b1101);
      drive(1'b1, id);
      for (int i = 6; i >= 0; i--) drive(1'b1, a[i*4 +: 4]);
      drive(1'b1, c);
      drive(1'b1, 4'hF);
   endtask

   task automatic quiet(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(!bus_oe && !rd_en, req, {bus_oe, rd_en}, 0);
      end
   endtask

   // Legal read with matching ID; abort_at >= 0 aborts before that response nibble.
   task automatic run_read(input logic [27:0] a, input logic [3:0] c, input int abort_at, input string dtag);
      logic [3:0]  exp_q[$];
      logic [27:0] base;
      logic        regsp;
      logic [7:0]  b;
      base  = exp_base(a, c);
      regsp = ~a[22];
      exp_q.push_back(4'hF);
      exp_q.push_back(4'h5);
      exp_q.push_back(4'h5);
      exp_q.push_back(4'h0);
      for (int k = 0; k < (1 << c[2:0]); k++) begin
         b = mem_byte(regsp, base + 28'(k));
         exp_q.push_back(b[3:0]);
         exp_q.push_back(b[7:4]);
      end
      exp_q.push_back(4'hF);
      send_header(STRAP, a, c);
      for (int k = 0; k < exp_q.size(); k++) begin
         @(negedge clk);
         if (k == abort_at) begin
            frame_n = 1'b0;
            bus_in  = 4'h0;
            @(negedge clk);
            check(!bus_oe, "R9", bus_oe, 0);
            frame_n = 1'b1;
            bus_in  = 4'hF;
            quiet(3, "R9");
            return;
         end
         if (k == 0)      check(bus_oe && bus_out == exp_q[k], "R1", {bus_oe, bus_out}, {1'b1, exp_q[k]});
         else if (k < 4)  check(bus_oe && bus_out == exp_q[k], "R5", {bus_oe, bus_out}, {1'b1, exp_q[k]});
         else if (k == exp_q.size() - 1)
                          check(bus_oe && bus_out == exp_q[k], "R7", {bus_oe, bus_out}, {1'b1, exp_q[k]});
         else             check(bus_oe && bus_out == exp_q[k], dtag, {bus_oe, bus_out}, {1'b1, exp_q[k]});
      end
      @(negedge clk);
      check(!bus_oe, "R7", bus_oe, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [27:0] a;
      logic [3:0]  c;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(!bus_oe && !rd_en, "R10", {bus_oe, rd_en}, 0);
      rst_n = 1'b1;
      quiet(2, "R10");

      // Directed corner cases
      run_read(28'hFF4_1234, 4'd0, -1, "R6");   // array, junk high bits
      run_read(28'hAB2_5678, 4'd0, -1, "R6");   // register space
      run_read(28'h0123_4A7 | 28'h040_0000, 4'd0, -1, "R3");
      run_read(28'h045_6789, 4'd1, -1, "R4");
      run_read(28'h047_0003, 4'd2, -1, "R4");
      run_read(28'h04A_BC1D, 4'd4, -1, "R4");
      run_read(28'h051_22FF, 4'd7, -1, "R4");
      run_read(28'h312_3457, 4'd2, -1, "R4");   // register space burst

      send_header(4'h5, 28'h040_0000, 4'd0);
      quiet(20, "R2");
      send_header(4'h5, 28'h040_0000, 4'd7);
      quiet(20, "R2");
      send_header(STRAP, 28'h040_0010, 4'd3);
      quiet(12, "R8");
      send_header(STRAP, 28'h040_0010, 4'd15);
      quiet(12, "R8");

      // Abort during the address, restarting at once
      drive(1'b0, 4'b1101);
      drive(1'b1, STRAP);
      drive(1'b1, 4'h9);
      drive(1'b1, 4'h9);
      run_read(28'h044_4441, 4'd1, -1, "R9");
      // Abort during the data phase, then a clean read
      run_read(28'h046_0000, 4'd4, 9, "R9");
      run_read(28'h046_0020, 4'd0, -1, "R9");

      // Constrained random mix
      for (int i = 0; i < 60; i++) begin
         int sel;
         a = 28'($urandom);
         case ($urandom % 5)
            0: c = 4'd0;
            1: c = 4'd1;
            2: c = 4'd2;
            3: c = 4'd4;
            default: c = 4'd7;
         endcase
         sel = $urandom % 10;
         if (sel == 0) begin
            send_header(STRAP ^ 4'(1 + $urandom % 15), a, c);
            quiet(10, "R2");
         end else if (sel == 1) begin
            send_header(STRAP, a, 4'(8 + $urandom % 8));
            quiet(8, "R8");
         end else if (sel == 2) begin
            run_read(a, c, int'($urandom % 6), "R9");
         end else begin
            run_read(a, c, -1, "R4");
         end
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule